// File: doc/BRIEF.md
# Register-Programmed Root Clock Generator with Fractional M/N Divider

The block produces a divided clock from one of two source clock enables: a reference enable and a PLL enable. Each source is given as a clock-enable on a datapath clock that runs at twice the source rate, so every enable pulse marks one source half-cycle and all logic stays single-edge. A prescaler divides by whole or half-integer ratios. An optional accumulator stage after it adds M on every prescaled period, modulo N. This gives an average ratio of M/N, with a duty threshold that software programs.

Software uses a small word-addressed register bus. It writes a configuration word and the M, N and D values into shadow registers, then sets the update bit in the command register. The hardware copies the whole shadow set into the active set at the next output period boundary, which avoids runt pulses, and clears the bit. Software polls the bit low to learn that the new rate is in effect. Two outputs are provided: a level clock and a one-cycle event pulse per output period.

Top module: `clkroot_gen`

## Requirements
- R1: A synchronous active-low reset clears every shadow and active register and the pending bit. The reference source is then selected with a period of 2 half-ticks, and every register reads 0.
- R2: Register words are addressed as 0 = configuration, 1 = M, 2 = N-code, 3 = D-code and 4 = command. Configuration keeps bits 13:0; bits 31:14 of a write have no effect and read 0. M, N-code and D-code keep and return their low 16 bits.
- R3: Writes to the configuration, M, N-code or D-code registers change neither `clk_out` nor `out_ce` until an update has been applied.
- R4: Writing 1 to command bit 0 sets the pending flag from the next clock. The command register reads the pending flag in bit 0, and the flag clears when the update is applied.
- R5: A pending update is applied in the cycle in which an output period completes, and the period counters then restart from zero. If the active source code is reserved, or the M/N stage is engaged with M = 0, the update is applied on the next clock instead.
- R6: Configuration bits 10:8 select the source: 0 = reference enable, 1 = PLL enable. Any other code gives no ticks, and `out_ce` stays low.
- R7: Configuration bits 4:0 hold code h. The prescaled period is h+1 source half-ticks for h ≥ 1 and 2 half-ticks for h = 0. In bypass, `clk_out` is high while twice the half-tick phase is below the period.
- R8: The M/N stage is engaged when configuration bits 13:12 equal 2 and the N-code is nonzero. Then N = (~N-code + M) mod 2^16, and each prescaled period adds M to an accumulator modulo N. `out_ce` fires on each wrap, and `clk_out` is high while twice the accumulator is below ~D-code. In all other cases the stage is bypassed and each prescaled period is one output period.
- R9: With the PLL enable high on every clock, code h = 15 and no M/N stage give one output per 16 clocks. Code h = 1 with M = 144 and N = 15625 gives 144 outputs per 31250 clocks.
- R10: A second update request made while one is pending merges with it: a single application clears the flag, and the flag stays clear afterwards.
- R11: `out_ce` is a one-clock pulse, registered one clock after the half-tick that completes an output period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock, twice the source rate |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_ce | input | 1 | Reference source half-cycle enable |
| pll_ce | input | 1 | PLL source half-cycle enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| clk_out | output | 1 | Divided output clock level |
| out_ce | output | 1 | One-cycle pulse per output period |

## Verification
The assertions check on every cycle that:
- a command write raises the pending flag;
- the active set cannot change without a pending update;
- a reserved source keeps the event output quiet;
- a pending update is applied at once when no boundary can come;
- the phase stays inside the period;
- every event leaves the phase at zero.

Only the bench scenarios can show the division ratios, including the half-integer, 100 MHz and 7.3728 MHz cases. The same holds for the duty shape, the masking of the configuration upper bits, and the merging of repeated requests. These come from a behavioural model that is compared on every clock.

// File: rtl/clkroot_gen.sv
module clkroot_gen #(
  parameter int MND_W = 16,
  parameter int DW    = 32,
  parameter int AW    = 3,
  parameter int HW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_ce,
  input  logic          pll_ce,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          clk_out,
  output logic          out_ce
);
  localparam int CFG_W = 14;
  localparam int PW    = HW + 1;
  localparam logic [AW-1:0] A_CFG = AW'(0);
  localparam logic [AW-1:0] A_M   = AW'(1);
  localparam logic [AW-1:0] A_N   = AW'(2);
  localparam logic [AW-1:0] A_D   = AW'(3);
  localparam logic [AW-1:0] A_CMD = AW'(4);

  logic [CFG_W-1:0] sh_cfg;
  logic [MND_W-1:0] sh_m, sh_n, sh_d;
  logic [2:0]       ac_src;
  logic [HW-1:0]    ac_h;
  logic [1:0]       ac_mode;
  logic [MND_W-1:0] ac_m, ac_n, ac_d;
  logic             pend;
  logic [PW-1:0]    phase;
  logic [MND_W-1:0] acc;

  logic [PW-1:0]    period;
  logic             tick, mnd_on, pre_wrap, wrap_hit, event_now, idle, apply, cmd_req;
  logic [MND_W-1:0] n_val, dthr, acc_nx;
  logic [MND_W:0]   sum;
  logic             unused_hi;

  assign unused_hi = ^bus_wdata[DW-1:CFG_W];
  assign period    = (ac_h == '0) ? PW'(2) : {1'b0, ac_h} + PW'(1);
  assign tick      = (ac_src == 3'd0) ? ref_ce : (ac_src == 3'd1) ? pll_ce : 1'b0;
  assign mnd_on    = (ac_mode == 2'd2) && (ac_n != '0);
  assign n_val     = ~ac_n + ac_m;
  assign dthr      = ~ac_d;
  assign pre_wrap  = tick && (phase == period - PW'(1));
  assign sum       = {1'b0, acc} + {1'b0, ac_m};
  assign wrap_hit  = sum >= {1'b0, n_val};
  assign acc_nx    = wrap_hit ? (acc + ac_m - n_val) : (acc + ac_m);
  assign event_now = mnd_on ? (pre_wrap && wrap_hit) : pre_wrap;
  assign idle      = (ac_src > 3'd1) || (mnd_on && ac_m == '0);
  assign apply     = pend && (event_now || idle);
  assign cmd_req   = bus_wr && (bus_addr == A_CMD) && bus_wdata[0];

  assign clk_out = mnd_on ? ({acc, 1'b0} < {1'b0, dthr})
                          : ({phase, 1'b0} < {1'b0, period});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_cfg  <= '0;
      sh_m    <= '0;
      sh_n    <= '0;
      sh_d    <= '0;
      ac_src  <= '0;
      ac_h    <= '0;
      ac_mode <= '0;
      ac_m    <= '0;
      ac_n    <= '0;
      ac_d    <= '0;
      pend    <= 1'b0;
      phase   <= '0;
      acc     <= '0;
      out_ce  <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_CFG) sh_cfg <= bus_wdata[CFG_W-1:0];
      if (bus_wr && bus_addr == A_M)   sh_m   <= bus_wdata[MND_W-1:0];
      if (bus_wr && bus_addr == A_N)   sh_n   <= bus_wdata[MND_W-1:0];
      if (bus_wr && bus_addr == A_D)   sh_d   <= bus_wdata[MND_W-1:0];
      pend   <= (pend && !apply) || cmd_req;
      out_ce <= event_now;
      if (apply) begin
        ac_src  <= sh_cfg[10:8];
        ac_h    <= sh_cfg[HW-1:0];
        ac_mode <= sh_cfg[13:12];
        ac_m    <= sh_m;
        ac_n    <= sh_n;
        ac_d    <= sh_d;
        phase   <= '0;
        acc     <= '0;
      end else if (tick) begin
        phase <= pre_wrap ? '0 : phase + PW'(1);
        if (pre_wrap && mnd_on) acc <= acc_nx;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = {{(DW-CFG_W){1'b0}}, sh_cfg};
      A_M:     bus_rdata = {{(DW-MND_W){1'b0}}, sh_m};
      A_N:     bus_rdata = {{(DW-MND_W){1'b0}}, sh_n};
      A_D:     bus_rdata = {{(DW-MND_W){1'b0}}, sh_d};
      A_CMD:   bus_rdata = {{(DW-1){1'b0}}, pend};
      default: bus_rdata = '0;
    endcase
  end

  assert_pend_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |=> pend);

  assert_hold_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> ($stable(ac_src) && $stable(ac_h) && $stable(ac_mode) &&
               $stable(ac_m) && $stable(ac_n) && $stable(ac_d)));

  assert_quiet_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_src > 3'd1) |=> !out_ce);

  assert_idle_apply_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && ac_src > 3'd1 && !(bus_wr && bus_addr == A_CMD)) |=> !pend);

  assert_phase_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    phase < period);

  assert_event_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_ce |-> phase == '0);
endmodule

// File: tb/clkroot_gen_tb_top.sv
module clkroot_gen_tb_top;
  localparam int MASK = 32'hFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_ce = 1'b0;
  logic        pll_ce = 1'b1;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        clk_out, out_ce;

  int checks = 0, failures = 0;
  int ev_cnt = 0, rise_cnt = 0, hi_cnt = 0;
  logic prev_oce = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  clkroot_gen dut_i (
    .clk(clk), .rst_n(rst_n), .ref_ce(ref_ce), .pll_ce(pll_ce),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .clk_out(clk_out), .out_ce(out_ce));

  initial begin
    int rc;
    rc = 0;
    forever begin
      @(negedge clk);
      rc++;
      ref_ce = (rc % 3 == 0);
    end
  end

  // behavioural reference model
  int s_cfg, s_m, s_n, s_d, a_cfg, a_m, a_n, a_d;
  int m_pend, m_phase, m_acc, m_oce;
  always @(posedge clk) begin
    int src, h, mode, per, t, mnd, nv, pw, s, wr, ev, idl, ap;
    if (!rst_n) begin
      s_cfg = 0; s_m = 0; s_n = 0; s_d = 0;
      a_cfg = 0; a_m = 0; a_n = 0; a_d = 0;
      m_pend = 0; m_phase = 0; m_acc = 0; m_oce = 0;
    end else begin
      src = (a_cfg >> 8) & 7; h = a_cfg & 31; mode = (a_cfg >> 12) & 3;
      per = (h == 0) ? 2 : h + 1;
      t = (src == 0) ? int'(ref_ce) : (src == 1) ? int'(pll_ce) : 0;
      mnd = (mode == 2 && a_n != 0);
      nv = ((~a_n) + a_m) & MASK;
      pw = (t != 0 && m_phase == per - 1);
      s = m_acc + a_m;
      wr = (s >= nv);
      ev = mnd ? (pw && wr) : pw;
      idl = (src > 1) || (mnd && a_m == 0);
      ap = m_pend && (ev || idl);
      if (ap) begin
        a_cfg = s_cfg; a_m = s_m; a_n = s_n; a_d = s_d;
        m_phase = 0; m_acc = 0;
      end else if (t != 0) begin
        m_phase = pw ? 0 : m_phase + 1;
        if (pw && mnd) m_acc = wr ? s - nv : s;
      end
      m_pend = (m_pend && !ap) || (bus_wr && bus_addr == 3'd4 && bus_wdata[0]);
      if (bus_wr && bus_addr == 3'd0) s_cfg = int'(bus_wdata) & 32'h3FFF;
      if (bus_wr && bus_addr == 3'd1) s_m = int'(bus_wdata) & MASK;
      if (bus_wr && bus_addr == 3'd2) s_n = int'(bus_wdata) & MASK;
      if (bus_wr && bus_addr == 3'd3) s_d = int'(bus_wdata) & MASK;
      m_oce = ev;
    end
  end

  // cycle comparison (R11 timing of out_ce, R7/R8 levels)
  always @(posedge clk) begin
    int h, per, mnd, ek;
    #5;
    if (rst_n) begin
      h = a_cfg & 31;
      per = (h == 0) ? 2 : h + 1;
      mnd = (((a_cfg >> 12) & 3) == 2 && a_n != 0);
      ek = mnd ? int'(2 * m_acc < ((~a_d) & MASK)) : int'(2 * m_phase < per);
      checks++;
      if (int'(clk_out) != ek || int'(out_ce) != m_oce) begin
        failures++;
        $display("FAIL %s model mismatch clk_out/out_ce actual=%0d/%0d expected=%0d/%0d",
                 cur_req, clk_out, out_ce, ek, m_oce);
      end
      if (out_ce) ev_cnt++;
      if (out_ce && !prev_oce) rise_cnt++;
      if (clk_out) hi_cnt++;
      prev_oce = out_ce;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a[2:0]; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    bus_addr = a[2:0];
    #1;
    d = int'(bus_rdata);
    @(negedge clk);
  endtask

  task automatic poll(output int n);
    int d;
    n = 0;
    do begin
      rd(4, d);
      n++;
    end while ((d & 1) != 0 && n < 100000);
  endtask

  task automatic window(input int n);
    ev_cnt = 0; rise_cnt = 0; hi_cnt = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int d, n, nreg, dreg;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(a, d);
      chk("R1 readback after reset", d, 0);
    end
    window(60);
    chk_rng("R1 ref source, period 2 half-ticks", ev_cnt, 9, 11);

    // R2 masking, R3 shadowing
    cur_req = "R3";
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); chk("R2 config upper bits ignored", d, 32'h3FFF);
    wr(1, 32'hABCD_1234);
    rd(1, d); chk("R2 M low 16 bits", d, 32'h1234);
    wr(3, 32'h5555_00FF);
    rd(3, d); chk("R2 D low 16 bits", d, 32'h00FF);
    window(60);
    chk_rng("R3 output unchanged by shadow writes", ev_cnt, 9, 11);

    // R6 reserved source
    cur_req = "R6";
    wr(4, 32'h1);
    poll(n);
    window(200);
    chk("R6 reserved source gives no events", ev_cnt, 0);

    // R5 idle apply, R4 readback, R9 100 MHz case, R11 pulse width
    cur_req = "R5";
    wr(0, (1 << 8) | 15);
    wr(4, 32'h1);
    rd(4, d); chk("R4 pending reads 1 after request", d & 1, 1);
    poll(n);
    chk_rng("R5 idle source applies at once", n, 1, 2);
    cur_req = "R9";
    window(1600);
    chk_rng("R9 div 8 gives 1 event per 16 clocks", ev_cnt, 99, 101);
    chk("R11 out_ce is single-cycle", ev_cnt, rise_cnt);

    // R7 half-integer period
    cur_req = "R7";
    wr(0, (1 << 8) | 4);
    wr(4, 32'h1);
    poll(n);
    window(500);
    chk_rng("R7 h=4 gives period of 5 half-ticks", ev_cnt, 99, 101);

    // R6 reference selection with sparse enable
    cur_req = "R6";
    wr(0, 3);
    wr(4, 32'h1);
    poll(n);
    window(600);
    chk_rng("R6 ref every 3 clocks, h=3 -> 12 clocks", ev_cnt, 49, 51);

    // R8 bypass when N-code is zero
    cur_req = "R8";
    wr(2, 0);
    wr(0, (2 << 12) | (1 << 8) | 7);
    wr(4, 32'h1);
    poll(n);
    window(800);
    chk_rng("R8 zero N-code bypasses M/N stage", ev_cnt, 99, 101);

    // R9 fractional case
    cur_req = "R9";
    nreg = (~(15625 - 144)) & MASK;
    dreg = (~15625) & MASK;
    wr(1, 144);
    wr(2, nreg);
    wr(3, dreg);
    wr(0, (2 << 12) | (1 << 8) | 1);
    wr(4, 32'h1);
    poll(n);
    window(31250);
    chk_rng("R9 M=144 N=15625 gives 144 events", ev_cnt, 143, 145);
    chk_rng("R8 duty near half", 2 * hi_cnt, 30750, 31750);

    // R5 boundary wait, R10 merge
    cur_req = "R10";
    wr(0, (1 << 8) | 15);
    do @(negedge clk); while (!out_ce);
    wr(4, 32'h1);
    repeat (40) @(negedge clk);
    rd(4, d); chk("R5 update waits for period boundary", d & 1, 1);
    wr(4, 32'h1);
    rd(4, d); chk("R10 second request keeps one pending", d & 1, 1);
    poll(n);
    repeat (300) @(negedge clk);
    rd(4, d); chk("R10 merged request leaves nothing pending", d & 1, 0);
    window(1600);
    chk_rng("R10 new rate after merged update", ev_cnt, 99, 101);

    finish_run();
  end
endmodule